// File: doc/BRIEF.md
# Variable-Length Instruction Byte Parser

This block takes a stream of instruction bytes, one per accepted transfer, and assembles a decoded record for a small subset of a 16-bit two-operand instruction set. Four families are recognised: register/memory move (opcodes 88h-8Bh), register/memory add (00h-03h), the immediate group (80h-83h, where only the ADD sub-operation is accepted) and the short accumulator add with an immediate (04h-05h). The parser takes the opcode byte first. It then takes the operand-mode byte, the displacement bytes and the immediate bytes in that fixed order. The opcode and the operand-mode byte together decide how many of the later bytes are present.

When the last byte of an instruction has been taken, the parser pulses a done flag. The flag comes with the total byte count and with a record that stays frozen until the next byte is accepted. The record holds the opcode, the direction/sign bit, the width bit, the three operand-mode fields, a 16-bit displacement and a 16-bit immediate. Bytes that cannot start a supported instruction raise a one-cycle error, and parsing starts again at the next byte. The parser does not execute instructions, form addresses or accept prefixes.

Top module: `instr_byte_parser`

## Requirements
- R1: A synchronous reset, applied at any time including in the middle of an instruction, clears done and err and makes the next accepted byte an opcode byte. in_ready is low while reset is high and high otherwise.
- R2: For opcodes 88h-8Bh and 00h-03h a second byte follows. After done, the outputs are as follows: wbit is opcode bit 0, dbit is opcode bit 1, mode is bits 7:6 of the second byte, regf is bits 5:3 and rmf is bits 2:0. With mode=11 the instruction is 2 bytes long and disp and imm both read 0.
- R3: With mode=01 exactly one displacement byte follows the second byte, and disp shows it sign-extended to 16 bits.
- R4: With mode=10 two displacement bytes follow, low byte first, and disp shows them as one 16-bit value.
- R5: With mode=00 and rmf=110 two direct-address bytes follow, low byte first, and disp shows them as one 16-bit value. With mode=00 and any other rmf value no displacement byte follows and disp reads 0.
- R6: For opcodes 80h-83h with regf=000, the immediate bytes follow any displacement bytes. The immediate size depends on opcode bits 1:0 (sign bit, width bit). 00 and 10 give one byte, zero-extended. 01 gives two bytes, low byte first. 11 gives one byte, sign-extended to 16 bits.
- R7: For opcodes 80h-83h, a second byte with regf other than 000 makes err high for exactly one cycle after that byte is accepted. No done pulse occurs, and the next byte is treated as an opcode byte.
- R8: Opcodes 04h and 05h have no operand-mode byte. In this case mode, regf and rmf read 0. Opcode 04h takes one immediate byte, zero-extended, for a length of 2. Opcode 05h takes a low and then a high immediate byte, for a length of 3.
- R9: An opcode byte outside 00h-05h, 80h-83h and 88h-8Bh makes err high for exactly one cycle after it is accepted. No done pulse occurs, and the next accepted byte is treated as an opcode byte.
- R10: done is high for exactly the one cycle after the last byte of a supported instruction is accepted. At that point length equals the number of bytes of the instruction (2 to 6 in this subset). done stays low after every earlier byte, and the record does not change while no byte is accepted.
- R11: A byte is taken only in a cycle in which in_valid and in_ready are both high. Idle cycles of any length between bytes do not change the decoded result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | A byte is offered on in_byte |
| in_byte | input | 8 | Offered instruction byte |
| in_ready | output | 1 | Parser can take a byte |
| done | output | 1 | One-cycle pulse when an instruction is complete |
| err | output | 1 | One-cycle pulse on an unsupported byte |
| length | output | LEN_W (3) | Byte count of the completed instruction |
| opcode | output | 8 | Opcode byte of the instruction |
| dbit | output | 1 | Direction bit, or sign bit in the immediate group |
| wbit | output | 1 | Width bit, 1 for word |
| mode | output | 2 | Addressing-mode field |
| regf | output | 3 | Register field |
| rmf | output | 3 | Register/memory field |
| disp | output | 16 | Displacement, sign-extended when one byte |
| imm | output | 16 | Immediate, extended as the opcode requires |

## Verification
The bench builds the parser with the default LEN_W of 3. This width covers every length the subset can produce, from the 2-byte register forms up to the 6-byte immediate-group add with a two-byte displacement. Directed instructions exercise each mode value, the direct-address exception, all four sign/width pairs and both short forms. Randomly drawn fields and idle gaps then mix those paths with resets and error bytes, and each decoded record is checked against expected values that the bench builds from the fields it chose.

// File: rtl/ibp_pkg.sv
package ibp_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [2:0] {K_BAD, K_MOV, K_ADD, K_GRP, K_ACC} kind_e;
  typedef enum logic [2:0] {P_OP, P_MODRM, P_DLO, P_DHI, P_ILO, P_IHI} phase_e;

  // family of an opcode byte
  function automatic kind_e classify(input logic [BYTE_W-1:0] op);
    if (op[7:2] == 6'b100010) return K_MOV;
    if (op[7:2] == 6'b000000) return K_ADD;
    if (op[7:2] == 6'b100000) return K_GRP;
    if (op[7:1] == 7'b0000010) return K_ACC;
    return K_BAD;
  endfunction

  // number of displacement bytes implied by the mode / rm pair
  function automatic logic [1:0] disp_count(input logic [1:0] md, input logic [2:0] rm);
    case (md)
      2'b01:   return 2'd1;
      2'b10:   return 2'd2;
      2'b00:   return (rm == 3'b110) ? 2'd2 : 2'd0;
      default: return 2'd0;
    endcase
  endfunction

  // number of immediate bytes for a family and its sign/width bits
  function automatic logic [1:0] imm_count(input kind_e k, input logic s, input logic w);
    case (k)
      K_GRP:   return (w && !s) ? 2'd2 : 2'd1;
      K_ACC:   return w ? 2'd2 : 2'd1;
      default: return 2'd0;
    endcase
  endfunction

  // byte to word, sign or zero extension
  function automatic logic [WORD_W-1:0] widen(input logic [BYTE_W-1:0] b, input logic sx);
    return sx ? {{BYTE_W{b[BYTE_W-1]}}, b} : {{BYTE_W{1'b0}}, b};
  endfunction
endpackage

// File: rtl/ibp_op_decode.sv
module ibp_op_decode
  import ibp_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output kind_e             kind,
  output logic              has_modrm,
  output logic [1:0]        imm_n,
  output logic              imm_sx
);
  always_comb begin
    kind      = classify(op);
    has_modrm = (kind == K_MOV) || (kind == K_ADD) || (kind == K_GRP);
    imm_n     = imm_count(kind, op[1], op[0]);
    imm_sx    = (kind == K_GRP) && op[1] && op[0];
  end
endmodule

// File: rtl/ibp_modrm_plan.sv
module ibp_modrm_plan
  import ibp_pkg::*;
(
  input  logic [BYTE_W-1:0] mb,
  input  kind_e             kind,
  output logic [1:0]        md,
  output logic [2:0]        rg,
  output logic [2:0]        rm,
  output logic [1:0]        disp_n,
  output logic              fault
);
  always_comb begin
    md     = mb[7:6];
    rg     = mb[5:3];
    rm     = mb[2:0];
    disp_n = disp_count(md, rm);
    // only the add sub-operation of the immediate group is supported
    fault  = (kind == K_GRP) && (rg != 3'b000);
  end
endmodule

// File: rtl/ibp_sequencer.sv
module ibp_sequencer
  import ibp_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              in_ready,
  input  kind_e             dec_kind,
  input  logic              dec_has_modrm,
  input  logic [1:0]        dec_imm_n,
  input  logic              dec_imm_sx,
  input  logic [1:0]        pl_md,
  input  logic [2:0]        pl_rg,
  input  logic [2:0]        pl_rm,
  input  logic [1:0]        pl_disp_n,
  input  logic              pl_fault,
  output kind_e             kind_q,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  length,
  output logic [BYTE_W-1:0] opcode,
  output logic [1:0]        mode,
  output logic [2:0]        regf,
  output logic [2:0]        rmf,
  output logic [WORD_W-1:0] disp,
  output logic [WORD_W-1:0] imm
);
  localparam logic [LEN_W-1:0] ONE = {{(LEN_W-1){1'b0}}, 1'b1};

  phase_e           ph, ph_nx;
  logic [1:0]       rem_disp_q, rem_imm_q;
  logic             sx_q;
  logic [LEN_W-1:0] cnt_q;

  // named events for the checks below
  logic accept, step_fin, step_fault;
  logic fin, fault;

  assign in_ready = ~rst;
  assign accept   = in_valid && in_ready;

  always_comb begin
    ph_nx = ph;
    fin   = 1'b0;
    fault = 1'b0;
    case (ph)
      P_OP: begin
        if (dec_kind == K_BAD) fault = 1'b1;
        else ph_nx = dec_has_modrm ? P_MODRM : P_ILO;
      end
      P_MODRM: begin
        if (pl_fault) begin
          fault = 1'b1;
          ph_nx = P_OP;
        end else if (pl_disp_n != 2'd0) ph_nx = P_DLO;
        else if (rem_imm_q != 2'd0)     ph_nx = P_ILO;
        else                            fin   = 1'b1;
      end
      P_DLO: begin
        if (rem_disp_q == 2'd2)      ph_nx = P_DHI;
        else if (rem_imm_q != 2'd0)  ph_nx = P_ILO;
        else                         fin   = 1'b1;
      end
      P_DHI: begin
        if (rem_imm_q != 2'd0) ph_nx = P_ILO;
        else                   fin   = 1'b1;
      end
      P_ILO: begin
        if (rem_imm_q == 2'd2) ph_nx = P_IHI;
        else                   fin   = 1'b1;
      end
      default: fin = 1'b1;
    endcase
    if (fin) ph_nx = P_OP;
  end

  assign step_fin   = accept && fin;
  assign step_fault = accept && fault;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph         <= P_OP;
      done       <= 1'b0;
      err        <= 1'b0;
      cnt_q      <= '0;
      rem_disp_q <= 2'd0;
      rem_imm_q  <= 2'd0;
      sx_q       <= 1'b0;
      kind_q     <= K_BAD;
      length     <= '0;
      opcode     <= '0;
      mode       <= 2'b00;
      regf       <= 3'b000;
      rmf        <= 3'b000;
      disp       <= '0;
      imm        <= '0;
    end else begin
      done <= step_fin;
      err  <= step_fault;
      if (step_fin) length <= cnt_q + ONE;
      if (accept) begin
        ph    <= ph_nx;
        cnt_q <= cnt_q + ONE;
        case (ph)
          P_OP: begin
            if (dec_kind != K_BAD) begin
              cnt_q     <= ONE;
              opcode    <= in_byte;
              kind_q    <= dec_kind;
              rem_imm_q <= dec_imm_n;
              sx_q      <= dec_imm_sx;
              mode      <= 2'b00;
              regf      <= 3'b000;
              rmf       <= 3'b000;
              disp      <= '0;
              imm       <= '0;
            end
          end
          P_MODRM: begin
            mode       <= pl_md;
            regf       <= pl_rg;
            rmf        <= pl_rm;
            rem_disp_q <= pl_disp_n;
          end
          P_DLO:   disp <= widen(in_byte, 1'b1);
          P_DHI:   disp[WORD_W-1:BYTE_W] <= in_byte;
          P_ILO:   imm <= widen(in_byte, sx_q);
          default: imm[WORD_W-1:BYTE_W] <= in_byte;
        endcase
      end
    end
  end

  // R10: the completion flag never lasts two cycles
  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R10: no completion and no error unless a byte was taken
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !accept |=> (!done && !err));
  // R9: an error never coincides with a completion
  assert_err_excl_R9: assert property (@(posedge clk) disable iff (rst)
    !(done && err));
  // R3: one-byte displacement shows as sign-extended
  assert_disp8_sext_R3: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q != K_ACC && mode == 2'b01) |-> (disp[WORD_W-1:BYTE_W] == {BYTE_W{disp[BYTE_W-1]}}));
  // R6: sign/width 11 gives a sign-extended immediate
  assert_imm_sext_R6: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q == K_GRP && opcode[1:0] == 2'b11) |-> (imm[WORD_W-1:BYTE_W] == {BYTE_W{imm[BYTE_W-1]}}));
  // R8: short accumulator form lengths and empty mode fields
  assert_acc_len_R8: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q == K_ACC) |-> ((length == (opcode[0] ? 3'd3 : 3'd2)) && mode == 2'b00 && rmf == 3'b000));
  // R5: direct address adds two bytes to a register/memory move
  assert_direct_len_R5: assert property (@(posedge clk) disable iff (rst)
    (done && kind_q == K_MOV && mode == 2'b00 && rmf == 3'b110) |-> (length == 3'd4));
  // R10: completed lengths stay within the subset
  assert_len_range_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> (length >= 3'd2 && length <= 3'd6));
endmodule

// File: rtl/instr_byte_parser.sv
module instr_byte_parser
  import ibp_pkg::*;
#(
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              done,
  output logic              err,
  output logic [LEN_W-1:0]  length,
  output logic [7:0]        opcode,
  output logic              dbit,
  output logic              wbit,
  output logic [1:0]        mode,
  output logic [2:0]        regf,
  output logic [2:0]        rmf,
  output logic [15:0]       disp,
  output logic [15:0]       imm
);
  kind_e      dec_kind, kind_q;
  logic       dec_has_modrm, dec_imm_sx, pl_fault;
  logic [1:0] dec_imm_n, pl_md, pl_disp_n;
  logic [2:0] pl_rg, pl_rm;

  ibp_op_decode u_dec (
    .op        (in_byte),
    .kind      (dec_kind),
    .has_modrm (dec_has_modrm),
    .imm_n     (dec_imm_n),
    .imm_sx    (dec_imm_sx)
  );

  ibp_modrm_plan u_plan (
    .mb     (in_byte),
    .kind   (kind_q),
    .md     (pl_md),
    .rg     (pl_rg),
    .rm     (pl_rm),
    .disp_n (pl_disp_n),
    .fault  (pl_fault)
  );

  ibp_sequencer #(.LEN_W(LEN_W)) u_seq (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .in_byte       (in_byte),
    .in_ready      (in_ready),
    .dec_kind      (dec_kind),
    .dec_has_modrm (dec_has_modrm),
    .dec_imm_n     (dec_imm_n),
    .dec_imm_sx    (dec_imm_sx),
    .pl_md         (pl_md),
    .pl_rg         (pl_rg),
    .pl_rm         (pl_rm),
    .pl_disp_n     (pl_disp_n),
    .pl_fault      (pl_fault),
    .kind_q        (kind_q),
    .done          (done),
    .err           (err),
    .length        (length),
    .opcode        (opcode),
    .mode          (mode),
    .regf          (regf),
    .rmf           (rmf),
    .disp          (disp),
    .imm           (imm)
  );

  assign wbit = opcode[0];
  assign dbit = opcode[1];

  // R1: the parser is ready exactly when out of reset
  assert_ready_R1: assert property (@(posedge clk) in_ready == !rst);
endmodule

// File: tb/test_instr_byte_parser.sv
`timescale 1ns/1ps
module test_instr_byte_parser;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, done, err, dbit, wbit;
  logic [2:0]  length, regf, rmf;
  logic [7:0]  opcode;
  logic [1:0]  mode;
  logic [15:0] disp, imm;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  instr_byte_parser i_instr_byte_parser (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte), .in_ready(in_ready),
    .done(done), .err(err), .length(length), .opcode(opcode), .dbit(dbit), .wbit(wbit),
    .mode(mode), .regf(regf), .rmf(rmf), .disp(disp), .imm(imm)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [15:0] sext8(input logic [7:0] b);
    return {{8{b[7]}}, b};
  endfunction

  task automatic send(input logic [7:0] b);
    in_valid = 1'b1;
    in_byte  = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle();
    in_valid = 1'b0;
    in_byte  = 8'($urandom);
    @(negedge clk);
  endtask

  // kind: 0 move, 1 add, 2 immediate group, 3 short accumulator add
  task automatic run_instr(input int kind, input logic db, input logic wb, input logic [1:0] md,
                           input logic [2:0] rg, input logic [2:0] rm, input logic [15:0] dv,
                           input logic [15:0] iv, input int gapmax);
    logic [7:0]  bytes [8];
    int          n, nd, ni;
    logic [7:0]  op;
    logic [15:0] edisp, eimm;
    logic [1:0]  emd;
    logic [2:0]  erg, erm;
    string       ftag, dtag, itag;
    n = 0; nd = 0; ni = 0;
    case (kind)
      0:       op = {6'b100010, db, wb};
      1:       op = {6'b000000, db, wb};
      2:       op = {6'b100000, db, wb};
      default: op = {7'b0000010, wb};
    endcase
    bytes[n] = op; n++;
    if (kind != 3) begin
      bytes[n] = {md, rg, rm}; n++;
      nd = (md == 2'b01) ? 1 : ((md == 2'b10 || (md == 2'b00 && rm == 3'b110)) ? 2 : 0);
      emd = md; erg = rg; erm = rm;
      ftag = "R2";
    end else begin
      emd = 2'b00; erg = 3'b000; erm = 3'b000;
      ftag = "R8";
    end
    for (int k = 0; k < nd; k++) begin bytes[n] = (k == 0) ? dv[7:0] : dv[15:8]; n++; end
    edisp = (nd == 0) ? 16'h0000 : ((nd == 1) ? sext8(dv[7:0]) : dv);
    dtag  = (nd == 1) ? "R3" : ((md == 2'b10) ? "R4" : ((md == 2'b00) ? "R5" : "R2"));
    if (kind == 2) begin
      ni   = (wb && !db) ? 2 : 1;
      eimm = (ni == 2) ? iv : ((db && wb) ? sext8(iv[7:0]) : {8'h00, iv[7:0]});
      itag = "R6";
    end else if (kind == 3) begin
      ni   = wb ? 2 : 1;
      eimm = (ni == 2) ? iv : {8'h00, iv[7:0]};
      itag = "R8";
    end else begin
      eimm = 16'h0000;
      itag = "R2";
    end
    for (int k = 0; k < ni; k++) begin bytes[n] = (k == 0) ? iv[7:0] : iv[15:8]; n++; end
    for (int k = 0; k < n; k++) begin
      if (k != 0) begin
        int g;
        g = $urandom_range(gapmax, 0);
        for (int j = 0; j < g; j++) idle();
      end
      send(bytes[k]);
      if (k == 0) chk("R10", "done after opcode byte", 32'(done), 32'd0);
    end
    chk("R10", "done after last byte", 32'(done), 32'd1);
    chk("R9",  "err on valid instruction", 32'(err), 32'd0);
    chk("R10", "length", 32'(length), 32'(n));
    chk(ftag, "opcode", 32'(opcode), 32'(op));
    chk(ftag, "dbit", 32'(dbit), 32'(op[1]));
    chk(ftag, "wbit", 32'(wbit), 32'(op[0]));
    chk(ftag, "mode", 32'(emd) ^ 32'(mode) ^ 32'(emd), 32'(emd));
    chk(ftag, "regf", 32'(regf), 32'(erg));
    chk(ftag, "rmf", 32'(rmf), 32'(erm));
    chk(dtag, "disp", 32'(disp), 32'(edisp));
    chk(itag, "imm", 32'(imm), 32'(eimm));
    idle();
    chk("R10", "done pulse ended", 32'(done), 32'd0);
    chk("R10", "record held disp", 32'(disp), 32'(edisp));
    chk("R10", "record held imm", 32'(imm), 32'(eimm));
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0101));
    @(negedge clk);
    chk("R1", "in_ready during reset", 32'(in_ready), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "done after reset", 32'(done), 32'd0);
    chk("R1", "err after reset", 32'(err), 32'd0);
    chk("R1", "in_ready after reset", 32'(in_ready), 32'd1);

    // R2 register forms
    run_instr(0, 1'b1, 1'b1, 2'b11, 3'b100, 3'b011, 16'h0, 16'h0, 0);
    run_instr(0, 1'b0, 1'b1, 2'b11, 3'b011, 3'b100, 16'h0, 16'h0, 0);
    run_instr(1, 1'b1, 1'b0, 2'b11, 3'b001, 3'b111, 16'h0, 16'h0, 0);
    run_instr(1, 1'b0, 1'b0, 2'b11, 3'b111, 3'b001, 16'h0, 16'h0, 0);
    // R3, R4, R5 displacements
    run_instr(0, 1'b1, 1'b1, 2'b01, 3'b001, 3'b111, 16'h0080, 16'h0, 0);
    run_instr(1, 1'b0, 1'b1, 2'b01, 3'b010, 3'b000, 16'h007F, 16'h0, 0);
    run_instr(0, 1'b1, 1'b1, 2'b10, 3'b001, 3'b111, 16'h1247, 16'h0, 0);
    run_instr(0, 1'b1, 1'b1, 2'b00, 3'b001, 3'b110, 16'h1234, 16'h0, 0);
    run_instr(0, 1'b1, 1'b1, 2'b00, 3'b001, 3'b111, 16'h0, 16'h0, 0);
    // R6 immediate group, all sign/width pairs
    run_instr(2, 1'b0, 1'b1, 2'b10, 3'b000, 3'b001, 16'h2345, 16'h97FF, 0);
    run_instr(2, 1'b1, 1'b1, 2'b01, 3'b000, 3'b001, 16'h0080, 16'h00F0, 0);
    run_instr(2, 1'b0, 1'b0, 2'b11, 3'b000, 3'b010, 16'h0, 16'h00F0, 0);
    run_instr(2, 1'b1, 1'b0, 2'b11, 3'b000, 3'b010, 16'h0, 16'h0090, 0);
    run_instr(2, 1'b0, 1'b1, 2'b11, 3'b000, 3'b000, 16'h0, 16'h0123, 0);
    // R8 short forms
    run_instr(3, 1'b0, 1'b1, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0123, 0);
    run_instr(3, 1'b0, 1'b0, 2'b00, 3'b000, 3'b000, 16'h0, 16'h00FF, 0);

    // R9 unsupported opcodes, back to back with a valid one
    send(8'h0F);
    chk("R9", "err on bad opcode", 32'(err), 32'd1);
    chk("R9", "no done on bad opcode", 32'(done), 32'd0);
    send(8'h84);
    chk("R9", "err on second bad opcode", 32'(err), 32'd1);
    idle();
    chk("R9", "err one cycle", 32'(err), 32'd0);
    send(8'h06);
    chk("R9", "err on 06", 32'(err), 32'd1);
    run_instr(0, 1'b1, 1'b0, 2'b11, 3'b010, 3'b011, 16'h0, 16'h0, 0);

    // R7 immediate group with a non-add sub-operation
    send(8'h80);
    send({2'b11, 3'b011, 3'b000});
    chk("R7", "err on group fault", 32'(err), 32'd1);
    chk("R7", "no done on group fault", 32'(done), 32'd0);
    idle();
    chk("R7", "err one cycle", 32'(err), 32'd0);
    run_instr(3, 1'b0, 1'b1, 2'b00, 3'b000, 3'b000, 16'h0, 16'hBEEF, 0);

    // R1 reset in the middle of an instruction
    send(8'h8B);
    send(8'h86);
    rst = 1'b1;
    @(negedge clk);
    chk("R1", "in_ready in mid reset", 32'(in_ready), 32'd0);
    rst = 1'b0;
    chk("R1", "done after mid reset", 32'(done), 32'd0);
    run_instr(3, 1'b0, 1'b1, 2'b00, 3'b000, 3'b000, 16'h0, 16'h0123, 0);

    // R11 idle cycles do not disturb the record or consume bytes
    for (int k = 0; k < 5; k++) idle();
    chk("R11", "no done while idle", 32'(done), 32'd0);
    chk("R11", "record stable while idle", 32'(imm), 32'h0123);
    chk("R11", "ready while idle", 32'(in_ready), 32'd1);
    run_instr(2, 1'b0, 1'b1, 2'b10, 3'b000, 3'b101, 16'hA55A, 16'h5AA5, 3);

    // random mix
    for (int t = 0; t < 300; t++) begin
      int kind;
      logic [2:0] rg;
      kind = $urandom_range(3, 0);
      rg   = (kind == 2) ? 3'b000 : 3'($urandom);
      run_instr(kind, (kind == 3) ? 1'b0 : 1'($urandom), 1'($urandom), 2'($urandom),
                rg, 3'($urandom), 16'($urandom), 16'($urandom), 2);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule